// File: doc/BRIEF.md
# Quadrature Lock-In Demodulator

This block recovers the phase-coherent part of a modulated signal. Each accepted input sample is mixed with a sine and a cosine reference sample in the same clock cycle. Both products then pass through a third-order cascaded integrator-comb decimator. The block produces two slow estimates. X is half the amplitude times the cosine of the phase offset. Y is half the amplitude times the sine of that offset. A single-cycle strobe marks each new pair. X alone is enough to serve as an error signal for a locking loop; Y is there for users who want both components.

The decimation ratio R is sampled while reset is held and then stays fixed. Choosing R as a whole number of modulation periods places the comb nulls on the mixing product at twice the modulation frequency and on its harmonics, so only the DC term is left. The references are produced elsewhere and arrive alongside each sample.

A small sequencer with two states paces the comb section. In `SEQ_GATHER` it counts integrated products. When the R-th product of a frame is integrated, it takes the transition `GATHER_TO_DUMP`. In `SEQ_DUMP` the comb stages evaluate and the scaled results are registered. It always returns with `DUMP_TO_GATHER` on the next cycle, and counting carries on without a break.

Top module: `lockin_demod`

## Requirements
- R1: X is derived from the product of the input sample and the sine reference; Y is derived from the product of the input sample and the cosine reference. Both products are formed in the cycle the sample is accepted.
- R2: With a constant sample and constant references, and R a power of two, every result from the third onward equals the per-sample product exactly (X for the sine product, Y for the cosine product).
- R3: out_valid is a one-cycle pulse. Exactly one pulse occurs per R accepted samples. It is high in the cycle after the second rising edge that follows the edge accepting the R-th sample of a frame.
- R4: A cycle with in_valid low is ignored, whatever values sit on the data and reference inputs. It neither advances the sample count nor changes the filter state.
- R5: ratio_in is sampled only on edges where rst is high. Changing it afterwards has no effect on pulse spacing.
- R6: A requested ratio below 4 acts as 4, and a requested ratio above 4096 acts as 4096.
- R7: A synchronous reset clears all filter state. While rst is high, out_valid is 0 and X and Y are 0. After reset, for a constant per-sample product p, the first result equals floor(C(R,3)·p / 2^S), with S = 3·ceil(log2 R).
- R8: For an input sinusoid at the reference frequency with R a whole number of periods, the settled X and Y are within 1% of (A·Aref/2)·cos θ and (A·Aref/2)·sin θ.
- R9: X and Y change only on edges that raise out_valid, and hold their values between pulses.
- R10: The integrators wrap in two's complement. A long run of full-scale products at R = 4096 still yields exact settled results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also samples the ratio |
| ratio_in | input | 13 | Requested decimation ratio, unsigned |
| in_valid | input | 1 | Marks a sample to be accepted this cycle |
| in_sample | input | 16 | Signed input sample |
| ref_sin | input | 16 | Signed sine reference |
| ref_cos | input | 16 | Signed cosine reference |
| out_valid | output | 1 | One-cycle strobe for a new X/Y pair |
| x_out | output | 32 | Signed in-phase estimate |
| y_out | output | 32 | Signed quadrature estimate |

## Verification
Constant samples against constant references of opposite sign show that each channel uses its own reference and give exact values, including the first partial result after reset. Running that constant pattern with idle cycles full of junk data shows that unaccepted cycles leave no trace. A phase-shifted sinusoid at the reference frequency, run at two phases that place X in different quadrants, checks the cosine/sine split against the analytic amplitude. A full-scale pattern run over many maximum-length frames forces the integrators to wrap. The same run also covers clamping of an out-of-range ratio.

// File: rtl/lockin_pkg.sv
package lockin_pkg;

    // number of integrator and comb stages
    localparam int unsigned STAGES = 3;

    typedef enum logic [0:0] {
        SEQ_GATHER = 1'b0,
        SEQ_DUMP   = 1'b1
    } seq_state_t;

endpackage

// File: rtl/lockin_mixer.sv
module lockin_mixer #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned PROD_W = 2 * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic signed [DATA_W-1:0] ref_sin,
    input  logic signed [DATA_W-1:0] ref_cos,
    output logic                     prod_valid,
    output logic signed [PROD_W-1:0] prod_sin,
    output logic signed [PROD_W-1:0] prod_cos
);

    // both products are formed from the same accepted sample
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_valid <= 1'b0;
            prod_sin   <= '0;
            prod_cos   <= '0;
        end else begin
            prod_valid <= in_valid;
            if (in_valid) begin
                prod_sin <= in_sample * ref_sin;
                prod_cos <= in_sample * ref_cos;
            end
        end
    end

endmodule

// File: rtl/lockin_seq.sv
module lockin_seq
    import lockin_pkg::*;
#(
    parameter int unsigned RATIO_W   = 13,
    parameter int unsigned RATIO_MIN = 4,
    parameter int unsigned RATIO_MAX = 4096,
    parameter int unsigned SHIFT_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               prod_valid,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [SHIFT_W-1:0] shift_q,
    output logic               dump
);

    seq_state_t         state_q;
    seq_state_t         state_d;
    logic [RATIO_W-1:0] ratio_clamped;
    logic [SHIFT_W-1:0] shift_calc;
    logic [RATIO_W-1:0] cnt_q;
    logic               frame_end;

    // clamp the requested ratio into the supported range
    always_comb begin
        if (ratio_in < RATIO_W'(RATIO_MIN)) begin
            ratio_clamped = RATIO_W'(RATIO_MIN);
        end else if (ratio_in > RATIO_W'(RATIO_MAX)) begin
            ratio_clamped = RATIO_W'(RATIO_MAX);
        end else begin
            ratio_clamped = ratio_in;
        end
    end

    // ceil(log2(ratio)) is the bit length of ratio-1; scale by stage count
    always_comb begin
        int unsigned lg;
        lg = 0;
        for (int i = 0; i < int'(RATIO_W); i++) begin
            if (((ratio_clamped - RATIO_W'(1)) >> i) != '0) begin
                lg = i + 1;
            end
        end
        shift_calc = SHIFT_W'(STAGES * lg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= ratio_clamped;
            shift_q <= shift_calc;
        end
    end

    assign frame_end = prod_valid && (cnt_q == ratio_q - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (prod_valid) begin
            cnt_q <= frame_end ? '0 : cnt_q + RATIO_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: GATHER_TO_DUMP on frame end, DUMP_TO_GATHER always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_GATHER: if (frame_end) state_d = SEQ_DUMP;
            SEQ_DUMP:   state_d = SEQ_GATHER;
            default:    state_d = SEQ_GATHER;
        endcase
    end

    // outputs
    always_comb begin
        dump = 1'b0;
        unique case (state_q)
            SEQ_GATHER: dump = 1'b0;
            SEQ_DUMP:   dump = 1'b1;
            default:    dump = 1'b0;
        endcase
    end

endmodule

// File: rtl/lockin_cic.sv
module lockin_cic
    import lockin_pkg::*;
#(
    parameter int unsigned PROD_W  = 32,
    parameter int unsigned ACC_W   = 68,
    parameter int unsigned OUT_W   = 32,
    parameter int unsigned SHIFT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prod_valid,
    input  logic signed [PROD_W-1:0] prod,
    input  logic                     dump,
    input  logic [SHIFT_W-1:0]       shift,
    output logic signed [OUT_W-1:0]  result
);

    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] scaled;

    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    // integrator chain, each stage fed by the previous stage's registered value
    for (genvar g = 0; g < int'(STAGES); g++) begin : gen_int
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] feed;
        if (g == 0) begin : g_first
            assign feed = prod_ext;
        end else begin : g_next
            assign feed = gen_int[g-1].acc_q;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (prod_valid) begin
                acc_q <= acc_q + feed;
            end
        end
    end

    // comb chain, evaluated once per frame at the low rate
    for (genvar k = 0; k < int'(STAGES); k++) begin : gen_comb
        logic signed [ACC_W-1:0] src;
        logic signed [ACC_W-1:0] dly_q;
        logic signed [ACC_W-1:0] diff;
        if (k == 0) begin : g_first
            assign src = gen_int[STAGES-1].acc_q;
        end else begin : g_next
            assign src = gen_comb[k-1].diff;
        end
        assign diff = src - dly_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q <= '0;
            end else if (dump) begin
                dly_q <= src;
            end
        end
    end

    assign scaled = gen_comb[STAGES-1].diff >>> shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (dump) begin
            result <= OUT_W'(scaled);
        end
    end

endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
    import lockin_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned RATIO_MIN = 4,
    parameter int unsigned RATIO_MAX = 4096,
    parameter int unsigned OUT_W     = 32,
    localparam int unsigned PROD_W   = 2 * DATA_W,
    localparam int unsigned RATIO_W  = $clog2(RATIO_MAX + 1),
    localparam int unsigned GROWTH   = STAGES * $clog2(RATIO_MAX),
    localparam int unsigned ACC_W    = PROD_W + GROWTH,
    localparam int unsigned SHIFT_W  = $clog2(GROWTH + 1),
    localparam int unsigned CHANNELS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [RATIO_W-1:0]       ratio_in,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic signed [DATA_W-1:0] ref_sin,
    input  logic signed [DATA_W-1:0] ref_cos,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  x_out,
    output logic signed [OUT_W-1:0]  y_out
);

    logic                     prod_valid;
    logic signed [PROD_W-1:0] prod_sin;
    logic signed [PROD_W-1:0] prod_cos;
    logic [RATIO_W-1:0]       ratio_lat;
    logic [SHIFT_W-1:0]       shift_lat;
    logic                     dump;
    logic signed [PROD_W-1:0] prod_ch [CHANNELS];
    logic signed [OUT_W-1:0]  res_ch  [CHANNELS];

    lockin_mixer #(.DATA_W(DATA_W)) u_mixer (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .ref_sin    (ref_sin),
        .ref_cos    (ref_cos),
        .prod_valid (prod_valid),
        .prod_sin   (prod_sin),
        .prod_cos   (prod_cos)
    );

    lockin_seq #(
        .RATIO_W   (RATIO_W),
        .RATIO_MIN (RATIO_MIN),
        .RATIO_MAX (RATIO_MAX),
        .SHIFT_W   (SHIFT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ratio_in   (ratio_in),
        .prod_valid (prod_valid),
        .ratio_q    (ratio_lat),
        .shift_q    (shift_lat),
        .dump       (dump)
    );

    // channel 0 carries the sine product (X), channel 1 the cosine product (Y)
    assign prod_ch[0] = prod_sin;
    assign prod_ch[1] = prod_cos;

    for (genvar c = 0; c < int'(CHANNELS); c++) begin : gen_ch
        lockin_cic #(
            .PROD_W  (PROD_W),
            .ACC_W   (ACC_W),
            .OUT_W   (OUT_W),
            .SHIFT_W (SHIFT_W)
        ) u_cic (
            .clk        (clk),
            .rst        (rst),
            .prod_valid (prod_valid),
            .prod       (prod_ch[c]),
            .dump       (dump),
            .shift      (shift_lat),
            .result     (res_ch[c])
        );
    end

    assign x_out = res_ch[0];
    assign y_out = res_ch[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= dump;
        end
    end

endmodule

// File: rtl/lockin_demod_chk.sv
module lockin_demod_chk #(
    parameter int unsigned RATIO_W   = 13,
    parameter int unsigned OUT_W     = 32,
    parameter int unsigned RATIO_MIN = 4,
    parameter int unsigned RATIO_MAX = 4096
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] x_out,
    input logic signed [OUT_W-1:0] y_out,
    input logic [RATIO_W-1:0]      ratio_lat
);

    // accepted-sample marks delayed to line up with out_valid
    logic             acc_d1;
    logic             acc_d2;
    logic             acc_d3;
    logic [RATIO_W:0] seen_q;
    logic [RATIO_W:0] seen_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_d1 <= 1'b0;
            acc_d2 <= 1'b0;
            acc_d3 <= 1'b0;
        end else begin
            acc_d1 <= in_valid;
            acc_d2 <= acc_d1;
            acc_d3 <= acc_d2;
        end
    end

    assign seen_now = seen_q + {{RATIO_W{1'b0}}, acc_d3};

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else begin
            seen_q <= out_valid ? '0 : seen_now;
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R3

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_now == {1'b0, ratio_lat})); // R3

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        seen_now <= {1'b0, ratio_lat}); // R4

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(x_out) && $stable(y_out))); // R9

    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ratio_lat >= RATIO_W'(RATIO_MIN)) && (ratio_lat <= RATIO_W'(RATIO_MAX))); // R6

    AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(ratio_lat)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && x_out == '0 && y_out == '0)); // R7

endmodule

bind lockin_demod lockin_demod_chk #(
    .RATIO_W   (RATIO_W),
    .OUT_W     (OUT_W),
    .RATIO_MIN (RATIO_MIN),
    .RATIO_MAX (RATIO_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .x_out     (x_out),
    .y_out     (y_out),
    .ratio_lat (ratio_lat)
);

// File: tb/tb_lockin_demod.sv
`timescale 1ns/1ps
module tb_lockin_demod;

    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [12:0]        ratio_in = 13'd16;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic signed [15:0] ref_sin = '0;
    logic signed [15:0] ref_cos = '0;
    logic               out_valid;
    logic signed [31:0] x_out;
    logic signed [31:0] y_out;

    int n_checks = 0;
    int n_fail   = 0;
    int res_n    = 0;
    int hold_err = 0;
    logic signed [31:0] rx [128];
    logic signed [31:0] ry [128];
    logic signed [31:0] hx = '0;
    logic signed [31:0] hy = '0;

    always #2.5 clk = ~clk;

    lockin_demod dut (
        .clk       (clk),
        .rst       (rst),
        .ratio_in  (ratio_in),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .ref_sin   (ref_sin),
        .ref_cos   (ref_cos),
        .out_valid (out_valid),
        .x_out     (x_out),
        .y_out     (y_out)
    );

    // result collector, sampled away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            hx = '0;
            hy = '0;
        end else if (out_valid) begin
            if (res_n < 128) begin
                rx[res_n] = x_out;
                ry[res_n] = y_out;
            end
            res_n = res_n + 1;
            hx = x_out;
            hy = y_out;
        end else if (x_out !== hx || y_out !== hy) begin
            hold_err = hold_err + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input real act, input real exp);
        real tol;
        tol = (exp < 0.0 ? -exp : exp) * 0.01;
        n_checks++;
        if ((act - exp) > tol || (exp - act) > tol) begin
            n_fail++;
            $display("FAIL %s actual=%0f expected=%0f", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [12:0] r);
        in_valid = 1'b0;
        rst      = 1'b1;
        ratio_in = r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input int s, input int rs, input int rc);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(s);
        ref_sin   = 16'(rs);
        ref_cos   = 16'(rc);
    endtask

    task automatic idle(input int cycles);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic t_reset_state();
        apply_reset(13'd16);
        check(out_valid == 1'b0, "R7 out_valid after reset", longint'(out_valid), 0);
        check(x_out == 0 && y_out == 0, "R7 outputs after reset", longint'(x_out), 0);
    endtask

    // constant pattern, R=16: per-sample products 2e6 and -3e6
    task automatic t_constant();
        int base;
        apply_reset(13'd16);
        base = res_n;
        for (int i = 0; i < 6 * 16; i++) push(1000, 2000, -3000);
        idle(6);
        check(res_n - base == 6, "R3 pulses per 96 samples at R=16", res_n - base, 6);
        check(rx[base] == 32'((longint'(560) * 2000000) >>> 12), "R7 first X after reset",
              rx[base], (longint'(560) * 2000000) >>> 12);
        check(ry[base] == 32'((longint'(560) * -3000000) >>> 12), "R7 first Y after reset",
              ry[base], (longint'(560) * -3000000) >>> 12);
        for (int k = 2; k < 6; k++) begin
            check(rx[base+k] == 2000000, "R1 R2 settled X uses sine product", rx[base+k], 2000000);
            check(ry[base+k] == -3000000, "R1 R2 settled Y uses cosine product", ry[base+k], -3000000);
        end
    endtask

    // idle cycles with junk on the data inputs must leave no trace
    task automatic t_gaps();
        int base;
        apply_reset(13'd8);
        base = res_n;
        for (int i = 0; i < 5 * 8; i++) begin
            push(-700, 1500, 900);
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 16'(12345 + i);
            ref_sin   = 16'(-321 * i);
            ref_cos   = 16'(777);
            @(negedge clk);
        end
        idle(6);
        check(res_n - base == 5, "R4 pulses count accepted samples only", res_n - base, 5);
        check(rx[base+3] == -1050000, "R4 X unaffected by idle cycles", rx[base+3], -1050000);
        check(ry[base+4] == -630000, "R4 Y unaffected by idle cycles", ry[base+4], -630000);
    endtask

    task automatic t_latch();
        int base;
        apply_reset(13'd8);
        ratio_in = 13'd32;
        base = res_n;
        for (int i = 0; i < 4 * 8; i++) push(300, 400, 500);
        idle(6);
        check(res_n - base == 4, "R5 ratio change after reset ignored", res_n - base, 4);
    endtask

    task automatic t_first_after_reset();
        int base;
        apply_reset(13'd8);
        base = res_n;
        for (int i = 0; i < 8; i++) push(100, 100, -100);
        idle(6);
        check(res_n - base == 1, "R7 one result after fresh reset", res_n - base, 1);
        check(rx[base] == 1093, "R7 state cleared by reset", rx[base], 1093);
    endtask

    task automatic t_clamp_low();
        int base;
        apply_reset(13'd0);
        base = res_n;
        for (int i = 0; i < 24; i++) push(50, 60, 70);
        idle(6);
        check(res_n - base == 6, "R6 ratio 0 acts as 4", res_n - base, 6);
        check(rx[base+5] == 3000, "R6 R2 settled X at R=4", rx[base+5], 3000);
    endtask

    // full-scale products over long frames: integrators must wrap
    task automatic t_wrap_high();
        int base;
        apply_reset(13'd8191);
        base = res_n;
        for (int i = 0; i < 6 * 4096; i++) push(-32768, -32768, 32767);
        idle(6);
        check(res_n - base == 6, "R6 ratio 8191 acts as 4096", res_n - base, 6);
        check(rx[base+5] == 32'sd1073741824, "R10 X exact after wrap", rx[base+5], 1073741824);
        check(ry[base+5] == -32'sd1073709056, "R10 Y exact after wrap", ry[base+5], -1073709056);
    endtask

    task automatic t_sine(input real phase_deg);
        int   base;
        real  amp;
        real  th;
        real  w;
        amp  = 20000.0;
        th   = phase_deg * PI / 180.0;
        w    = 2.0 * PI / 16.0;
        apply_reset(13'd64);
        base = res_n;
        for (int n = 0; n < 5 * 64; n++) begin
            push(int'(amp * $sin(w * n + th)), int'(32767.0 * $sin(w * n)),
                 int'(32767.0 * $cos(w * n)));
        end
        idle(6);
        check(res_n - base == 5, "R8 pulses for sinusoid", res_n - base, 5);
        for (int k = 3; k < 5; k++) begin
            check_near("R8 X amplitude", real'(rx[base+k]), amp * 32767.0 / 2.0 * $cos(th));
            check_near("R8 Y amplitude", real'(ry[base+k]), amp * 32767.0 / 2.0 * $sin(th));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_constant();
        t_gaps();
        t_latch();
        t_first_after_reset();
        t_clamp_low();
        t_sine(30.0);
        t_sine(120.0);
        t_wrap_high();
        check(hold_err == 0, "R9 outputs held between pulses", hold_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule